// File: doc/BRIEF.md
# Ethernet PHY Power-Mode Controller

This block decides which parts of a 10/100 Ethernet transceiver are powered and clocked. It holds three control bits that sit in the management register space: a whole-chip sleep bit, a receive-idle gating bit and a transmit-float bit. From these bits, the current line speed and the receiver's signal-detect flag, it drives registered enables. These enables cover the receive analog/DSP chain, the receive clock, the transmit line drivers, the transmit clock pin's output driver and a weak pull-up on that pin. It also drives a keep-alive enable for the management interface.

The management frame parser reaches the bits through a plain write strobe with an address and data, plus a combinational read-data bus. The management interface stays alive in every mode, so a sleeping chip can still be woken by a register write. Receive-idle gating frees the receiver while the line is quiet and wakes it as soon as signal detect rises. Gating is bypassed at 10 Mb/s.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After reset all three control bits are 0. Reads of addresses 0 and 16 return 0. The receive path, receive clock, line driver, transmit clock output and keep-alive enables are 1, and the pull-up enable is 0.
- R2: Writing 1 to bit 11 of address 0 puts the chip to sleep. While the bit is set, the receive path, receive clock, line driver, transmit clock output and pull-up enables are all 0.
- R3: The keep-alive enable stays 1 in every mode. Writes and reads through the management port behave the same during sleep as when awake.
- R4: With bit 0 of address 16 set, 100 Mb/s selected (speed_10m = 0) and sig_det low, the receive path and receive clock enables are 0.
- R5: In that mode, the receive path and receive clock enables return to 1 whenever sig_det is high. No other action is needed.
- R6: With speed_10m = 1, bit 0 of address 16 has no effect, and the receive enables stay 1 unless the chip sleeps.
- R7: With bit 12 of address 16 set, the line driver and transmit clock output enables are 0 and the pull-up enable is 1 (outside sleep). The receive enables are unaffected.
- R8: A control bit changes only on reset or on a write to its own address. Writes to other addresses, and other bit positions of addresses 0 and 16, change nothing.
- R9: Address 0 reads the sleep bit at bit 11. Address 16 reads the transmit-float bit at bit 12 and the receive-gating bit at bit 0. Every other bit and every other address reads 0, and a write is visible on the next read cycle.
- R10: Every enable output is registered. It reflects the bits and inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_wr_en | input | 1 | Register write strobe |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for mgmt_addr |
| speed_10m | input | 1 | 1 = 10 Mb/s mode, 0 = 100 Mb/s |
| sig_det | input | 1 | Receive signal detect |
| rx_path_en | output | 1 | Receive equalizer/recovery/DSP enable |
| rx_clk_en | output | 1 | Receive clock output enable |
| tx_drv_en | output | 1 | Transmit line driver enable |
| tx_clk_oe | output | 1 | Transmit clock pin output enable |
| tx_clk_pullup_en | output | 1 | Weak pull-up enable on transmit clock pin |
| mgmt_keep_en | output | 1 | Management interface keep-alive enable |

## Verification
Two events can meet in one cycle: a write that changes a control bit, and a change of sig_det or speed_10m. The bench provokes this by raising sig_det on the same edge that sets the sleep bit or the receive-gating bit, and by switching speed while a gating write lands. A behavioural model in the bench latches the old bits and the new inputs at each edge and predicts each enable one cycle later. At every falling edge it compares each output and the read bus, so the order in which the two causes take effect is judged directly.

// File: rtl/phy_pwr_pkg.sv
// Shared types for the PHY power-mode controller.
// Assumes: one bit per control function; field order is internal only.
package phy_pwr_pkg;

    typedef struct packed {
        logic sleep;      // whole-chip power-down
        logic rx_gate;    // receive-idle gating
        logic tx_float;   // transmit high-impedance
    } pwr_cfg_t;

    typedef struct packed {
        logic rx_path;
        logic rx_clk;
        logic tx_drv;
        logic tx_clk_oe;
        logic tx_pullup;
        logic keep;
    } pwr_en_t;

    localparam pwr_en_t EN_RESET = '{rx_path: 1'b1, rx_clk: 1'b1, tx_drv: 1'b1,
                                     tx_clk_oe: 1'b1, tx_pullup: 1'b0, keep: 1'b1};

endpackage

// File: rtl/phy_pwr_regs.sv
// Control-bit storage and read mux for the power-mode controller.
// Assumes: single-cycle write strobe; read data is combinational on address.
module phy_pwr_regs
    import phy_pwr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int BASE_ADDR = 0,
    parameter int EXT_ADDR  = 16,
    parameter int SLEEP_BIT = 11,
    parameter int RXG_BIT   = 0,
    parameter int TXF_BIT   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output pwr_cfg_t          cfg
);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(EXT_ADDR);

    logic hit_base, hit_ext;
    assign hit_base = wr_en && (addr == A_BASE);
    assign hit_ext  = wr_en && (addr == A_EXT);

    // Store control bits on writes to their own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (hit_base) cfg.sleep <= wdata[SLEEP_BIT];
            if (hit_ext) begin
                cfg.rx_gate  <= wdata[RXG_BIT];
                cfg.tx_float <= wdata[TXF_BIT];
            end
        end
    end

    // Place each bit at its read position; unused bits read 0.
    always_comb begin
        rdata = '0;
        if (addr == A_BASE) begin
            rdata[SLEEP_BIT] = cfg.sleep;
        end else if (addr == A_EXT) begin
            rdata[RXG_BIT] = cfg.rx_gate;
            rdata[TXF_BIT] = cfg.tx_float;
        end
    end

    // R3
    wr_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EXT && cfg.sleep) |=> (cfg.rx_gate == $past(wdata[RXG_BIT])));

    // R8
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_EXT) |=> $stable(cfg.tx_float));

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_BASE) |=> $stable(cfg.sleep));

endmodule

// File: rtl/phy_pwr_policy.sv
// Turns control bits, speed and signal detect into registered enables.
// Assumes: sig_det and speed_10m are already synchronous to clk.
module phy_pwr_policy
    import phy_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwr_cfg_t cfg,
    input  logic     speed_10m,
    input  logic     sig_det,
    output pwr_en_t  en
);
    logic rx_ok, tx_ok;
    pwr_en_t en_d;

    // Receiver runs unless asleep or gated on a quiet 100 Mb/s line.
    assign rx_ok = !cfg.sleep && (!cfg.rx_gate || speed_10m || sig_det);
    // Transmitter runs unless asleep or floated.
    assign tx_ok = !cfg.sleep && !cfg.tx_float;

    // Next-state enables.
    always_comb begin
        en_d.rx_path   = rx_ok;
        en_d.rx_clk    = rx_ok;
        en_d.tx_drv    = tx_ok;
        en_d.tx_clk_oe = tx_ok;
        en_d.tx_pullup = !cfg.sleep && cfg.tx_float;
        en_d.keep      = 1'b1;
    end

    // Register the enables so each lands one clock after its cause.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= EN_RESET;
        else        en <= en_d;
    end

    // R2
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg.sleep) |-> !(en.rx_path || en.rx_clk || en.tx_drv || en.tx_clk_oe || en.tx_pullup));

    // R5
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg.sleep && sig_det) |-> (en.rx_path && en.rx_clk));

    // R6
    slow_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg.sleep && speed_10m) |-> (en.rx_path && en.rx_clk));

    // R7
    float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg.sleep && cfg.tx_float) |-> (!en.tx_drv && !en.tx_clk_oe && en.tx_pullup));

endmodule

// File: rtl/phy_pwr_ctrl.sv
// Top of the PHY power-mode controller: register port plus enable policy.
// Assumes: synchronous active-low reset; management port in the clk domain.
module phy_pwr_ctrl
    import phy_pwr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_wr_en,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              speed_10m,
    input  logic              sig_det,
    output logic              rx_path_en,
    output logic              rx_clk_en,
    output logic              tx_drv_en,
    output logic              tx_clk_oe,
    output logic              tx_clk_pullup_en,
    output logic              mgmt_keep_en
);
    pwr_cfg_t cfg;
    pwr_en_t  en;

    phy_pwr_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .BASE_ADDR(0), .EXT_ADDR(16),
        .SLEEP_BIT(11), .RXG_BIT(0), .TXF_BIT(12)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(mgmt_wr_en), .addr(mgmt_addr),
        .wdata(mgmt_wdata), .rdata(mgmt_rdata), .cfg(cfg)
    );

    phy_pwr_policy u_policy (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .speed_10m(speed_10m),
        .sig_det(sig_det), .en(en)
    );

    // Unpack the enable bundle onto the ports.
    assign rx_path_en       = en.rx_path;
    assign rx_clk_en        = en.rx_clk;
    assign tx_drv_en        = en.tx_drv;
    assign tx_clk_oe        = en.tx_clk_oe;
    assign tx_clk_pullup_en = en.tx_pullup;
    assign mgmt_keep_en     = en.keep;

    // R3
    keep_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> mgmt_keep_en);

endmodule

// File: tb/phy_pwr_ctrl_test.sv
// Bench: behavioural model updated on each rising edge, compared at each falling edge.
module phy_pwr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        spd10 = 1'b0;
    logic        sd = 1'b0;
    logic        rxp, rxc, txd, txoe, txpu, keep;

    always #4 clk = ~clk;   // 125 MHz

    phy_pwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mgmt_wr_en(wr), .mgmt_addr(addr),
        .mgmt_wdata(wdata), .mgmt_rdata(rdata), .speed_10m(spd10), .sig_det(sd),
        .rx_path_en(rxp), .rx_clk_en(rxc), .tx_drv_en(txd), .tx_clk_oe(txoe),
        .tx_clk_pullup_en(txpu), .mgmt_keep_en(keep)
    );

    int total = 0, bad = 0, cycles = 0;
    string tag = "R1";
    bit started = 0;

    // model state
    bit m_sleep, m_rxg, m_txf;
    bit e_rxp, e_rxc, e_txd, e_txoe, e_txpu, e_keep;

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            m_sleep = 0; m_rxg = 0; m_txf = 0;
            e_rxp = 1; e_rxc = 1; e_txd = 1; e_txoe = 1; e_txpu = 0; e_keep = 1;
        end else begin
            e_rxp  = !m_sleep && (!m_rxg || spd10 || sd);
            e_rxc  = e_rxp;
            e_txd  = !m_sleep && !m_txf;
            e_txoe = e_txd;
            e_txpu = !m_sleep && m_txf;
            e_keep = 1;
            if (wr && addr == 5'd0) m_sleep = wdata[11];
            if (wr && addr == 5'd16) begin m_rxg = wdata[0]; m_txf = wdata[12]; end
        end
    end

    task automatic chk(string name, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic [15:0] e_rd;
            e_rd = '0;
            if (addr == 5'd0) e_rd[11] = m_sleep;
            else if (addr == 5'd16) begin e_rd[12] = m_txf; e_rd[0] = m_rxg; end
            chk("rx_path_en", 16'(rxp), 16'(e_rxp));
            chk("rx_clk_en", 16'(rxc), 16'(e_rxc));
            chk("tx_drv_en", 16'(txd), 16'(e_txd));
            chk("tx_clk_oe", 16'(txoe), 16'(e_txoe));
            chk("tx_clk_pullup_en", 16'(txpu), 16'(e_txpu));
            chk("mgmt_keep_en", 16'(keep), 16'(e_keep));
            chk("mgmt_rdata", rdata, e_rd);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state and idle read-back
        tag = "R1";
        idle(3);
        rst_n = 1;
        addr = 5'd0; idle(2);
        addr = 5'd16; idle(2);
        // R4: gating on a quiet 100 Mb/s line
        tag = "R4";
        wr_reg(5'd16, 16'h0001);
        idle(3);
        // R5: wake on signal detect, sleep again when quiet
        tag = "R5";
        sd = 1; idle(3);
        sd = 0; idle(2);
        sd = 1; idle(1); sd = 0; idle(2);
        // R6: 10 Mb/s bypasses gating
        tag = "R6";
        spd10 = 1; idle(3);
        spd10 = 0; idle(2);
        // R7: transmit float, receive unaffected
        tag = "R7";
        wr_reg(5'd16, 16'h1000);
        sd = 1; idle(2); sd = 0; idle(2);
        // R8: foreign writes leave bits alone
        tag = "R8";
        wr_reg(5'd0, 16'hF7FF);
        wr_reg(5'd5, 16'hFFFF);
        addr = 5'd16; idle(3);
        // R9: read positions and other addresses
        tag = "R9";
        wr_reg(5'd16, 16'hFFFF);
        addr = 5'd16; idle(1);
        addr = 5'd3; idle(1);
        addr = 5'd17; idle(1);
        wr_reg(5'd16, 16'h0000);
        addr = 5'd16; idle(1);
        // R2: sleep, with sig_det toggling
        tag = "R2";
        wr_reg(5'd0, 16'h0800);
        addr = 5'd0; idle(1);
        sd = 1; idle(2); sd = 0; idle(2);
        // R3: management still works while asleep
        tag = "R3";
        wr_reg(5'd16, 16'h1001);
        addr = 5'd16; idle(2);
        wr_reg(5'd0, 16'h0000);
        idle(2);
        // R10: same-cycle causes
        tag = "R10";
        sd = 0;
        @(negedge clk); wr = 1; addr = 5'd0; wdata = 16'h0800; sd = 1;
        @(negedge clk); wr = 0; sd = 0;
        idle(2);
        wr_reg(5'd0, 16'h0000);
        @(negedge clk); wr = 1; addr = 5'd16; wdata = 16'h0001; spd10 = 1;
        @(negedge clk); wr = 0; spd10 = 0;
        idle(2);
        @(negedge clk); sd = 1;
        @(negedge clk); sd = 0; wr = 1; addr = 5'd16; wdata = 16'h0000;
        @(negedge clk); wr = 0;
        idle(3);
        finish_run();
    end
endmodule